// File: doc/BRIEF.md
# Multiframe Phase Compare and Buffer Alignment

This block sits on the receive data path of a converter link. It holds incoming lane words in a delay buffer and chooses where in that buffer it reads. That choice keeps the word leaving the block in step with a reference multiframe pulse produced elsewhere on the chip.

The block takes two single-cycle markers. One is the multiframe marker recovered from the received lanes. The other is the reference multiframe pulse. The block counts the digital clock cycles from a received marker to the next reference pulse. It folds that count into a signed phase using the multiframe period, then limits the result to plus or minus the adjustment range. A limited result raises an error flag.

The measured phase does not change the data path by itself. The block applies it only when an alignment request is pending, and only on a reference pulse. The read tap therefore never moves partway through a multiframe. At rest the buffer delays data by the centre tap. An applied offset lengthens the delay by that many words, or shortens it for a negative offset.

Top module: `lmfc_align`

## Requirements
- R1: While reset is high and on the first cycle after it, `offset_o` is 0 and `err_o` is 0.
- R2: A measurement starts on a cycle where `lmfc_rcv_i` is high. It completes on the n-th following cycle where `lmfc_ref_i` is high, giving count n. If both markers are high in the same cycle, n is 0. The signed phase is n when n ≤ PERIOD/2, and n − PERIOD otherwise.
- R3: A phase greater than RANGE is limited to +RANGE, and a phase less than −RANGE is limited to −RANGE. Applying a limited phase sets `err_o` to 1. Applying an in-range phase sets `err_o` to 0. `offset_o` always lies within ±RANGE.
- R4: `offset_o` and `err_o` change only in the cycle after a cycle in which `lmfc_ref_i` was high and an alignment request was pending. A request is set by a cycle with `align_req_i` high. An alignment request alone does not move the offset.
- R5: A request made before any measurement has completed stays pending and leaves `offset_o` at 0. It is applied on the reference pulse that completes the first measurement.
- R6: After each clock edge, `data_o` equals the `data_i` value sampled RANGE + `offset_o` edges earlier. The centre tap, RANGE, applies when the offset is 0.
- R7: If no reference pulse arrives by the (PERIOD − 1)-th cycle after a received marker, the measurement is abandoned. The last completed measurement is kept.
- R8: A received marker that arrives during a measurement restarts the count from that marker.
- R9: A measurement that completes while no request is pending leaves `offset_o` and `err_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Digital clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | DATA_W | Received lane word |
| lmfc_rcv_i | input | 1 | Multiframe marker recovered from the lanes, one-cycle pulse |
| lmfc_ref_i | input | 1 | Reference multiframe pulse, one-cycle pulse |
| align_req_i | input | 1 | Alignment request strobe |
| data_o | output | DATA_W | Aligned lane word |
| offset_o | output | OFF_W | Applied signed offset, two's complement |
| err_o | output | 1 | The applied offset was limited to the range edge |

## Verification
Several properties are checked on every cycle. The applied offset stays within the adjustment range. The error flag is only ever seen with the offset at a range edge. Offset and flag move only just after a reference pulse. Both are cleared on leaving reset. Other behaviours can only be shown by the bench's scenarios: the folding of the count into a signed phase, the exact limiting points, a pending request waiting for the first measurement, timeout and restart of a measurement, and the word-exact delay through the buffer.

// File: rtl/lmfc_align_pkg.sv
package lmfc_align_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_RANGE  = 128;
    localparam int DEF_PERIOD = 320;

    typedef enum logic { MTR_IDLE, MTR_COUNT } mtr_state_e;

    typedef struct packed {
        logic               err;
        logic signed [31:0] off;
    } phase_t;

    // Fold a marker-to-reference count into a signed phase, then limit it
    function automatic phase_t fold_phase(int n, int period, int range);
        phase_t r;
        int     w;
        w     = (n <= period / 2) ? n : n - period;
        r.err = (w > range) || (w < -range);
        if (w > range)
            r.off = range;
        else if (w < -range)
            r.off = -range;
        else
            r.off = w;
        return r;
    endfunction

endpackage

// File: rtl/lmfc_phase_meter.sv
module lmfc_phase_meter
    import lmfc_align_pkg::*;
#(
    parameter int PERIOD = DEF_PERIOD,
    parameter int RANGE  = DEF_RANGE,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   rcv_i,
    input  logic   ref_i,
    output logic   done_o,
    output phase_t res_o,
    output logic   have_o,
    output phase_t held_o
);

    mtr_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    int               n;

    always_comb begin
        done_o = 1'b0;
        n      = 0;
        if (rcv_i) begin
            done_o = ref_i;
        end else if (state_q == MTR_COUNT && ref_i) begin
            done_o = 1'b1;
            n      = int'(cnt_q);
        end
        res_o = fold_phase(n, PERIOD, RANGE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MTR_IDLE;
            cnt_q   <= '0;
            have_o  <= 1'b0;
            held_o  <= '0;
        end else begin
            if (rcv_i && !ref_i) begin
                state_q <= MTR_COUNT;
                cnt_q   <= CNT_W'(1);
            end else if (done_o) begin
                state_q <= MTR_IDLE;
            end else if (state_q == MTR_COUNT) begin
                if (cnt_q == CNT_W'(PERIOD - 1))
                    state_q <= MTR_IDLE;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
            if (done_o) begin
                held_o <= res_o;
                have_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lmfc_apply_ctrl.sv
module lmfc_apply_ctrl
    import lmfc_align_pkg::*;
#(
    parameter int OFF_W = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    align_req_i,
    input  logic                    ref_i,
    input  logic                    done_i,
    input  phase_t                  res_i,
    input  logic                    have_i,
    input  phase_t                  held_i,
    output logic signed [OFF_W-1:0] offset_o,
    output logic                    err_o
);

    logic   pend_q;
    logic   pend_eff;
    logic   apply;
    phase_t src;

    always_comb begin
        pend_eff = pend_q | align_req_i;
        apply    = ref_i & pend_eff & (done_i | have_i);
        src      = done_i ? res_i : held_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            offset_o <= '0;
            err_o    <= 1'b0;
        end else begin
            pend_q <= pend_eff & ~apply;
            if (apply) begin
                offset_o <= src.off[OFF_W-1:0];
                err_o    <= src.err;
            end
        end
    end

endmodule

// File: rtl/lmfc_delay_buf.sv
module lmfc_delay_buf #(
    parameter int DATA_W = 16,
    parameter int RANGE  = 128,
    parameter int OFF_W  = 9,
    localparam int DEPTH = 2 * RANGE + 1,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DATA_W-1:0]       data_i,
    input  logic signed [OFF_W-1:0] offset_i,
    output logic [DATA_W-1:0]       data_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    int                tap;

    always_ff @(posedge clk) begin
        if (rst)
            wr_ptr <= '0;
        else if (wr_ptr == PTR_W'(DEPTH - 1))
            wr_ptr <= '0;
        else
            wr_ptr <= wr_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        mem[wr_ptr] <= data_i;
    end

    // Newest word sits at wr_ptr-1; step back RANGE+offset entries
    always_comb begin
        tap = int'(wr_ptr) - 1 - (RANGE + int'(offset_i));
        if (tap < 0)
            tap = tap + DEPTH;
        data_o = mem[tap[PTR_W-1:0]];
    end

endmodule

// File: rtl/lmfc_align.sv
module lmfc_align
    import lmfc_align_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int RANGE  = DEF_RANGE,
    parameter int PERIOD = DEF_PERIOD,
    localparam int OFF_W = $clog2(RANGE + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    lmfc_rcv_i,
    input  logic                    lmfc_ref_i,
    input  logic                    align_req_i,
    output logic [DATA_W-1:0]       data_o,
    output logic signed [OFF_W-1:0] offset_o,
    output logic                    err_o
);

    logic   meas_done;
    logic   meas_have;
    phase_t meas_res;
    phase_t meas_held;

    lmfc_phase_meter #(.PERIOD(PERIOD), .RANGE(RANGE)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .rcv_i  (lmfc_rcv_i),
        .ref_i  (lmfc_ref_i),
        .done_o (meas_done),
        .res_o  (meas_res),
        .have_o (meas_have),
        .held_o (meas_held)
    );

    lmfc_apply_ctrl #(.OFF_W(OFF_W)) u_apply (
        .clk         (clk),
        .rst         (rst),
        .align_req_i (align_req_i),
        .ref_i       (lmfc_ref_i),
        .done_i      (meas_done),
        .res_i       (meas_res),
        .have_i      (meas_have),
        .held_i      (meas_held),
        .offset_o    (offset_o),
        .err_o       (err_o)
    );

    lmfc_delay_buf #(.DATA_W(DATA_W), .RANGE(RANGE), .OFF_W(OFF_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .data_i   (data_i),
        .offset_i (offset_o),
        .data_o   (data_o)
    );

endmodule

// File: rtl/lmfc_align_chk.sv
module lmfc_align_chk #(
    parameter int RANGE = 128,
    parameter int OFF_W = 9
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    lmfc_ref_i,
    input logic signed [OFF_W-1:0] offset_o,
    input logic                    err_o
);

    assert_offset_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(offset_o) <= RANGE) && (int'(offset_o) >= -RANGE));

    assert_err_at_edge_R3: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (int'(offset_o) == RANGE || int'(offset_o) == -RANGE));

    assert_change_after_ref_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(offset_o) || !$stable(err_o)) |-> $past(lmfc_ref_i));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (offset_o == '0 && !err_o));

endmodule

bind lmfc_align lmfc_align_chk #(.RANGE(RANGE), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lmfc_ref_i (lmfc_ref_i),
    .offset_o   (offset_o),
    .err_o      (err_o)
);

// File: tb/lmfc_align_bench.sv
module lmfc_align_bench;

    localparam int CLK_P  = 10;
    localparam int RANGE  = 128;
    localparam int PERIOD = 320;
    localparam int NV     = 10;

    // gap in cycles, expected applied offset, expected error flag (R2, R3)
    localparam int GAP     [NV] = '{0, 5, 128, 129, 160, 161, 191, 192, 300, 319};
    localparam int EXP_OFF [NV] = '{0, 5, 128, 128, 128, -128, -128, -128, -20, -1};
    localparam int EXP_ERR [NV] = '{0, 0, 0, 1, 1, 1, 1, 0, 0, 0};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [15:0]       din = '0;
    logic              rcv = 1'b0;
    logic              refp = 1'b0;
    logic              areq = 1'b0;
    logic [15:0]       dout;
    logic signed [8:0] offset;
    logic              err;

    int checks = 0;
    int fails  = 0;
    int prev_off;
    int prev_err;

    always #(CLK_P / 2) clk = ~clk;
    always @(negedge clk) din <= din + 16'd1;

    lmfc_align u_lmfc_align (
        .clk         (clk),
        .rst         (rst),
        .data_i      (din),
        .lmfc_rcv_i  (rcv),
        .lmfc_ref_i  (refp),
        .align_req_i (areq),
        .data_o      (dout),
        .offset_o    (offset),
        .err_o       (err)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(string req, int eoff, int eerr);
        chk(int'(offset) == eoff, {req, " offset"}, int'(offset), eoff);
        chk(int'(err) == eerr, {req, " err"}, int'(err), eerr);
    endtask

    task automatic chk_data(string req, int off);
        for (int i = 0; i < 3; i++) begin
            logic [15:0] exp_d;
            exp_d = din - 16'(RANGE + off);
            chk(dout == exp_d, req, int'(dout), int'(exp_d));
            @(posedge clk); #1;
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic pulse_ref();
        refp = 1'b1; @(posedge clk); #1; refp = 1'b0;
    endtask

    task automatic pulse_req();
        areq = 1'b1; @(posedge clk); #1; areq = 1'b0;
    endtask

    task automatic measure(int gap);
        rcv = 1'b1;
        if (gap == 0) refp = 1'b1;
        @(posedge clk); #1;
        rcv  = 1'b0;
        refp = 1'b0;
        if (gap > 0) begin
            tick(gap - 1);
            pulse_ref();
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(3);
        chk_out("R1 in reset", 0, 0);
        rst = 1'b0;
        tick(1);
        chk_out("R1 after reset", 0, 0);

        // R5: request before any measurement stays pending
        pulse_req();
        pulse_ref();
        chk_out("R5 no measurement yet", 0, 0);
        measure(7);
        chk_out("R5 pending applied at first measurement", 7, 0);

        tick(270);
        chk_data("R6 delay with offset 7", 7);
        prev_off = 7;
        prev_err = 0;

        for (int v = 0; v < NV; v++) begin
            measure(GAP[v]);
            chk_out("R9 measurement alone", prev_off, prev_err);
            pulse_req();
            chk_out("R4 request alone", prev_off, prev_err);
            pulse_ref();
            chk_out("R2 R3 applied phase", EXP_OFF[v], EXP_ERR[v]);
            chk_data("R6 aligned data", EXP_OFF[v]);
            prev_off = EXP_OFF[v];
            prev_err = EXP_ERR[v];
        end

        // R7: no reference within the period, measurement abandoned
        measure(5);
        pulse_req();
        pulse_ref();
        chk_out("R7 setup", 5, 0);
        rcv = 1'b1; @(posedge clk); #1; rcv = 1'b0;
        tick(PERIOD - 1);
        pulse_ref();
        pulse_req();
        pulse_ref();
        chk_out("R7 timeout keeps last", 5, 0);

        // R8: second received marker restarts the count
        rcv = 1'b1; @(posedge clk); #1; rcv = 1'b0;
        tick(10);
        measure(3);
        pulse_req();
        pulse_ref();
        chk_out("R8 restart", 3, 0);
        chk_data("R6 after restart", 3);

        // R1: reset clears a limited offset with error
        measure(129);
        pulse_req();
        pulse_ref();
        chk_out("R3 limited before reset", 128, 1);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        chk_out("R1 reset clears", 0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule